// File: doc/BRIEF.md
# Luma notch and peaking path

This block sharpens and cleans an 8-bit stream of luminance or composite video samples, one sample per clock. Each sample passes four stages in a fixed order. An optional high-frequency emphasis filter comes first. A notch follows that removes the colour subcarrier, tuned to either the 4.43 MHz or the 3.58 MHz standard. A sharpness stage adds a signed, weighted band-pass detail term back onto the unpeaked signal, using one of two band-pass shapes. A final gain stage restores the DC level that the chosen notch loses.

Composite sources use the notch. Separated-luma sources must run with the notch bypassed, because the notch would remove real picture detail there. All settings are plain level inputs, meant to be driven from configuration register fields. Bypassed stages take their value from the centre of the same delay line that feeds the filter. The path delay is therefore the same in every setting.

Top module: `luma_detail_path`

## Requirements
- R1: While reset is asserted, and on the first cycle after release with a zero input, `pix_out` reads 0.
- R2: The output produced from the sample captured at clock edge n appears on `pix_out` right after edge n+11, and this holds for every combination of settings.
- R3: With `emph_on`=1 the emphasis value is e(n) = floor((6·x(n) − x(n−1) − x(n+1)) / 4). With `emph_on`=0, e(n) = x(n).
- R4: With `trap_off`=0 and `trap_std`=0 (4.43 MHz), the notch value is c(n) = floor((e(n−2) + 4e(n−1) + 5e(n) + 4e(n+1) + e(n+2)) / 16).
- R5: With `trap_off`=0 and `trap_std`=1 (3.58 MHz), the notch value is c(n) = floor((e(n−2) + 4e(n−1) + 3e(n) + 4e(n+1) + e(n+2)) / 16).
- R6: With `trap_off`=1 the notch passes its input unchanged, c(n) = e(n), and `trap_std` has no effect.
- R7: The peaked value is p(n) = clamp(c(n) + floor(k·d(n)/8), 0, 255). Here k is `sharp_gain` read as 4-bit two's complement. With `peak_wide`=0, d(n) = 2c(n) − c(n−2) − c(n+2). With `peak_wide`=1, d(n) = 4c(n) − c(n−1) − c(n+1) − c(n−2) − c(n+2).
- R8: With `sharp_gain`=0 the peaked value is the notch value clamped to 0..255, whatever `peak_wide` is.
- R9: The output is min(255, floor(p(n)·G/16)). G is 16 when `trap_off`=1, 17 for the 4.43 MHz notch and 20 for the 3.58 MHz notch. The stage never lowers a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | IN_W | Unsigned luma or composite sample |
| emph_on | input | 1 | 1 switches the high-frequency emphasis filter in |
| trap_off | input | 1 | 1 bypasses the subcarrier notch (separated-luma inputs) |
| trap_std | input | 1 | Notch centre: 0 = 4.43 MHz, 1 = 3.58 MHz |
| peak_wide | input | 1 | Band-pass shape: 0 = narrow, 1 = wide |
| sharp_gain | input | SHARP_W | Signed sharpness weight applied to the detail term |
| pix_out | output | IN_W | Processed unsigned sample |

## Verification
The in-RTL properties are one-cycle relations around each stage register, so they assume nothing about sample values. They do assume that a setting read by a stage in a given cycle governs that stage's next register value. They therefore hold even while settings change. The end-to-end expectation formulas need each setting held steady for a sample's whole path through the block, about eleven cycles on either side of it. The stimulus changes settings only between long segments. A sample is compared only when its inputs and every stage it passes through fall inside one segment. Samples that straddle a change are skipped.

// File: rtl/luma_path_pkg.sv
package luma_path_pkg;

   typedef enum logic [1:0] {
      TRAP_NONE = 2'd0,
      TRAP_F443 = 2'd1,
      TRAP_F358 = 2'd2
   } trap_mode_e;

   // high-frequency emphasis: unity DC gain
   localparam int EMPH_TAPS  = 3;
   localparam int EMPH_COEF [EMPH_TAPS] = '{-1, 6, -1};
   localparam int EMPH_SHIFT = 2;

   // subcarrier notches, zero placed near each carrier at 13.5 MHz sampling
   localparam int NOTCH_TAPS = 5;
   localparam int NOTCH_443_COEF [NOTCH_TAPS] = '{1, 4, 5, 4, 1};
   localparam int NOTCH_358_COEF [NOTCH_TAPS] = '{1, 4, 3, 4, 1};
   localparam int NOTCH_SHIFT = 4;

   // detail band-pass shapes, zero DC gain
   localparam int BP_TAPS = 5;
   localparam int BP_NARROW_COEF [BP_TAPS] = '{-1, 0, 2, 0, -1};
   localparam int BP_WIDE_COEF   [BP_TAPS] = '{-1, -1, 4, -1, -1};

   // DC restoration per notch setting, in sixteenths
   localparam int GAIN_SHIFT = 4;
   localparam int GAIN_UNITY = 16;
   localparam int GAIN_443   = 17;
   localparam int GAIN_358   = 20;

endpackage

// File: rtl/lp_tapline.sv
module lp_tapline #(
   parameter int W    = 12,
   parameter int NTAP = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] d,
   output logic signed [W-1:0] taps [NTAP]
);

   if (NTAP < 1) begin : g_bad_ntap
      $error("lp_tapline: NTAP must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps <= '{default: '0};
      end else begin
         taps[0] <= d;
         for (int i = 1; i < NTAP; i++) begin
            taps[i] <= taps[i-1];
         end
      end
   end

endmodule

// File: rtl/lp_sym_fir.sv
module lp_sym_fir #(
   parameter int IW    = 12,
   parameter int OW    = 12,
   parameter int NTAP  = 5,
   parameter int COEF [NTAP] = '{1, 2, 3, 2, 1},
   parameter int SHIFT = 0
) (
   input  logic signed [IW-1:0] taps [NTAP],
   output logic signed [OW-1:0] y
);

   localparam int GUARD = 8;
   localparam int AW    = IW + GUARD;

   logic signed [AW-1:0] prod [NTAP];
   logic signed [AW-1:0] acc;

   if (NTAP % 2 == 0) begin : g_even_len
      $error("lp_sym_fir: NTAP must be odd");
   end
   if (OW > AW) begin : g_wide_out
      $error("lp_sym_fir: OW exceeds accumulator width");
   end

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      localparam logic signed [AW-1:0] CW = AW'(COEF[i]);
      if (COEF[i] != COEF[NTAP-1-i]) begin : g_asym
         $error("lp_sym_fir: coefficients must be symmetric");
      end
      assign prod[i] = AW'(taps[i]) * CW;
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NTAP; i++) begin
         acc = acc + prod[i];
      end
      y = OW'(acc >>> SHIFT);
   end

endmodule

// File: rtl/lp_peak_add.sv
module lp_peak_add #(
   parameter int IW     = 12,
   parameter int DW     = 16,
   parameter int KW     = 4,
   parameter int PW     = 8,
   parameter int KSHIFT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [IW-1:0] base,
   input  logic signed [DW-1:0] det_narrow,
   input  logic signed [DW-1:0] det_wide,
   input  logic                 shape_wide,
   input  logic signed [KW-1:0] weight,
   output logic        [PW-1:0] pix_q
);

   localparam int MW = DW + KW;
   localparam int SW = MW + 1;
   localparam logic signed [SW-1:0] PIX_MAX  = SW'((1 << PW) - 1);
   localparam logic signed [IW-1:0] BASE_MAX = IW'((1 << PW) - 1);

   if (IW >= SW) begin : g_bad_iw
      $error("lp_peak_add: base wider than sum");
   end
   if (IW <= PW) begin : g_bad_pw
      $error("lp_peak_add: base must be wider than the pixel");
   end

   logic signed [DW-1:0] det;
   logic signed [MW-1:0] scaled;
   logic signed [SW-1:0] sum;
   logic        [PW-1:0] clamped;

   always_comb begin
      det    = shape_wide ? det_wide : det_narrow;
      scaled = (MW'(det) * MW'(weight)) >>> KSHIFT;
      sum    = SW'(base) + SW'(scaled);
      if (sum < 0) begin
         clamped = '0;
      end else if (sum > PIX_MAX) begin
         clamped = '1;
      end else begin
         clamped = sum[PW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
      end else begin
         pix_q <= clamped;
      end
   end

   // zero weight leaves an in-range base untouched
   assert_flat_when_dull_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (weight == '0 && base >= 0 && base <= BASE_MAX) |=> (pix_q == $past(base[PW-1:0])));

   // zero weight with a negative base clamps to black
   assert_floor_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (weight == '0 && base < 0) |=> (pix_q == '0));

endmodule

// File: rtl/lp_dc_gain.sv
module lp_dc_gain
   import luma_path_pkg::*;
#(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pix_d,
   input  trap_mode_e    mode,
   output logic [PW-1:0] pix_q
);

   localparam int GW = 6;
   localparam int MW = PW + GW;
   localparam logic [MW-1:0] PIX_MAX = MW'((1 << PW) - 1);

   if (GAIN_358 >= (1 << GW) || GAIN_443 >= (1 << GW)) begin : g_bad_gain
      $error("lp_dc_gain: gain constant exceeds GW");
   end
   if (GAIN_UNITY != (1 << GAIN_SHIFT)) begin : g_bad_unity
      $error("lp_dc_gain: unity gain must equal 1 << GAIN_SHIFT");
   end

   logic [GW-1:0] gain;
   logic [MW-1:0] prod;
   logic [MW-1:0] scaled;
   logic [PW-1:0] next_pix;

   always_comb begin
      case (mode)
         TRAP_F443: gain = GW'(GAIN_443);
         TRAP_F358: gain = GW'(GAIN_358);
         default:   gain = GW'(GAIN_UNITY);
      endcase
      prod     = MW'(pix_d) * MW'(gain);
      scaled   = prod >> GAIN_SHIFT;
      next_pix = (scaled > PIX_MAX) ? '1 : scaled[PW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
      end else begin
         pix_q <= next_pix;
      end
   end

   assert_unity_when_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRAP_NONE) |=> (pix_q == $past(pix_d)));

   assert_never_attenuates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pix_q >= $past(pix_d)));

endmodule

// File: rtl/luma_detail_path.sv
module luma_detail_path
   import luma_path_pkg::*;
#(
   parameter int IN_W        = 8,
   parameter int INT_W       = 12,
   parameter int SHARP_W     = 4,
   parameter int SHARP_SHIFT = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic        [IN_W-1:0]    pix_in,
   input  logic                      emph_on,
   input  logic                      trap_off,
   input  logic                      trap_std,
   input  logic                      peak_wide,
   input  logic signed [SHARP_W-1:0] sharp_gain,
   output logic        [IN_W-1:0]    pix_out
);

   localparam int DET_W     = INT_W + 4;
   localparam int EMPH_MID  = EMPH_TAPS / 2;
   localparam int NOTCH_MID = NOTCH_TAPS / 2;
   localparam int BP_MID    = BP_TAPS / 2;

   if (INT_W < IN_W + 3) begin : g_bad_int_w
      $error("luma_detail_path: INT_W too narrow for emphasis overshoot");
   end
   if (SHARP_W < 2) begin : g_bad_sharp_w
      $error("luma_detail_path: SHARP_W must be at least 2");
   end

   // ---------------- emphasis stage ----------------
   logic signed [INT_W-1:0] x_ext;
   logic signed [INT_W-1:0] emph_taps [EMPH_TAPS];
   logic signed [INT_W-1:0] emph_y;
   logic signed [INT_W-1:0] emph_q;

   assign x_ext = signed'({{(INT_W-IN_W){1'b0}}, pix_in});

   lp_tapline #(.W(INT_W), .NTAP(EMPH_TAPS)) u_emph_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (x_ext),
      .taps  (emph_taps)
   );

   lp_sym_fir #(
      .IW(INT_W), .OW(INT_W), .NTAP(EMPH_TAPS), .COEF(EMPH_COEF), .SHIFT(EMPH_SHIFT)
   ) u_emph_fir (
      .taps (emph_taps),
      .y    (emph_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emph_q <= '0;
      end else begin
         emph_q <= emph_on ? emph_y : emph_taps[EMPH_MID];
      end
   end

   assert_emph_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !emph_on |=> (emph_q == $past(emph_taps[EMPH_MID])));

   // ---------------- subcarrier notch ----------------
   logic signed [INT_W-1:0] notch_taps [NOTCH_TAPS];
   logic signed [INT_W-1:0] notch_443_y;
   logic signed [INT_W-1:0] notch_358_y;
   logic signed [INT_W-1:0] notch_q;
   trap_mode_e              trap_mode;

   assign trap_mode = trap_off ? TRAP_NONE : (trap_std ? TRAP_F358 : TRAP_F443);

   lp_tapline #(.W(INT_W), .NTAP(NOTCH_TAPS)) u_notch_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (emph_q),
      .taps  (notch_taps)
   );

   lp_sym_fir #(
      .IW(INT_W), .OW(INT_W), .NTAP(NOTCH_TAPS), .COEF(NOTCH_443_COEF), .SHIFT(NOTCH_SHIFT)
   ) u_notch_443 (
      .taps (notch_taps),
      .y    (notch_443_y)
   );

   lp_sym_fir #(
      .IW(INT_W), .OW(INT_W), .NTAP(NOTCH_TAPS), .COEF(NOTCH_358_COEF), .SHIFT(NOTCH_SHIFT)
   ) u_notch_358 (
      .taps (notch_taps),
      .y    (notch_358_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         notch_q <= '0;
      end else begin
         case (trap_mode)
            TRAP_F443: notch_q <= notch_443_y;
            TRAP_F358: notch_q <= notch_358_y;
            default:   notch_q <= notch_taps[NOTCH_MID];
         endcase
      end
   end

   assert_trap_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_off |=> (notch_q == $past(notch_taps[NOTCH_MID])));

   // ---------------- detail peaking ----------------
   logic signed [INT_W-1:0] bp_taps [BP_TAPS];
   logic signed [DET_W-1:0] det_narrow;
   logic signed [DET_W-1:0] det_wide;
   logic        [IN_W-1:0]  peak_q;

   lp_tapline #(.W(INT_W), .NTAP(BP_TAPS)) u_bp_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (notch_q),
      .taps  (bp_taps)
   );

   lp_sym_fir #(
      .IW(INT_W), .OW(DET_W), .NTAP(BP_TAPS), .COEF(BP_NARROW_COEF), .SHIFT(0)
   ) u_bp_narrow (
      .taps (bp_taps),
      .y    (det_narrow)
   );

   lp_sym_fir #(
      .IW(INT_W), .OW(DET_W), .NTAP(BP_TAPS), .COEF(BP_WIDE_COEF), .SHIFT(0)
   ) u_bp_wide (
      .taps (bp_taps),
      .y    (det_wide)
   );

   lp_peak_add #(
      .IW(INT_W), .DW(DET_W), .KW(SHARP_W), .PW(IN_W), .KSHIFT(SHARP_SHIFT)
   ) u_peak (
      .clk        (clk),
      .rst_n      (rst_n),
      .base       (bp_taps[BP_MID]),
      .det_narrow (det_narrow),
      .det_wide   (det_wide),
      .shape_wide (peak_wide),
      .weight     (sharp_gain),
      .pix_q      (peak_q)
   );

   // ---------------- DC restoration ----------------
   lp_dc_gain #(.PW(IN_W)) u_gain (
      .clk   (clk),
      .rst_n (rst_n),
      .pix_d (peak_q),
      .mode  (trap_mode),
      .pix_q (pix_out)
   );

endmodule

// File: tb/test_luma_detail_path.sv
`timescale 1ns/1ps
module test_luma_detail_path;

   localparam int NSEG    = 10;
   localparam int SEG_LEN = 250;
   localparam int NS      = NSEG * SEG_LEN;
   localparam int PAD     = 16;
   localparam int OBS_LAG = 12;   // R2: result of edge n+11 seen at the negedge after it

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic        [7:0] pix_in = '0;
   logic              emph_on = 1'b0;
   logic              trap_off = 1'b0;
   logic              trap_std = 1'b0;
   logic              peak_wide = 1'b0;
   logic signed [3:0] sharp_gain = '0;
   logic        [7:0] pix_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int    x_arr  [NS+PAD];
   int    seg_of [NS+PAD];
   int    c_emph [NSEG];
   int    c_toff [NSEG];
   int    c_std  [NSEG];
   int    c_wide [NSEG];
   int    c_sharp[NSEG];
   int    c_ptn  [NSEG];
   string c_tag  [NSEG];

   luma_detail_path i_luma_detail_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_in     (pix_in),
      .emph_on    (emph_on),
      .trap_off   (trap_off),
      .trap_std   (trap_std),
      .peak_wide  (peak_wide),
      .sharp_gain (sharp_gain),
      .pix_out    (pix_out)
   );

   always #2 clk = ~clk;

   // ---------------- behavioural reference ----------------
   function automatic int xs(int i);
      if (i < 0 || i >= NS) return 0;
      return x_arr[i];
   endfunction

   function automatic int clampi(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int ef(int i, int s);   // R3
      if (c_emph[s] == 0) return xs(i);
      return (6 * xs(i) - xs(i-1) - xs(i+1)) >>> 2;
   endfunction

   function automatic int nf(int i, int s);   // R4 R5 R6
      int mid;
      if (c_toff[s] != 0) return ef(i, s);
      mid = (c_std[s] != 0) ? 3 : 5;
      return (ef(i-2, s) + 4 * ef(i-1, s) + mid * ef(i, s) + 4 * ef(i+1, s) + ef(i+2, s)) >>> 4;
   endfunction

   function automatic int pf(int n, int s);   // R7 R8
      int c0, d;
      c0 = nf(n, s);
      if (c_wide[s] != 0) d = 4 * c0 - nf(n-1, s) - nf(n+1, s) - nf(n-2, s) - nf(n+2, s);
      else                d = 2 * c0 - nf(n-2, s) - nf(n+2, s);
      return clampi(c0 + ((c_sharp[s] * d) >>> 3), 0, 255);
   endfunction

   function automatic int ref_out(int n);     // R9
      int s, g;
      s = seg_of[n];
      if (c_toff[s] != 0)     g = 16;
      else if (c_std[s] != 0) g = 20;
      else                    g = 17;
      return clampi((pf(n, s) * g) >>> 4, 0, 255);
   endfunction

   function automatic int gen_sample(int ptn, int i);
      case (ptn)
         0:       return (i % 20 == 3) ? 200 : ((i % 20 == 10) ? 90 : 0);
         1:       return int'($urandom_range(255, 0));
         2:       return ((i / 2) % 2 != 0) ? 255 : 0;
         default: return int'($urandom_range(255, 200));
      endcase
   endfunction

   task automatic check(string req, string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic set_seg(int s, int ptn, int em, int toff, int std, int wide, int k, string tag);
      c_ptn[s] = ptn; c_emph[s] = em; c_toff[s] = toff; c_std[s] = std;
      c_wide[s] = wide; c_sharp[s] = k; c_tag[s] = tag;
   endtask

   // ---------------- stimulus and comparison ----------------
   initial begin
      set_seg(0, 0, 0, 1, 0, 0,  0, "R2");  // plain delay of impulses
      set_seg(1, 1, 1, 1, 0, 0,  0, "R3");  // emphasis alone
      set_seg(2, 2, 0, 0, 0, 0,  0, "R4");  // 4.43 notch on fs/4 square
      set_seg(3, 1, 0, 0, 1, 0,  0, "R5");  // 3.58 notch
      set_seg(4, 1, 1, 1, 1, 0,  0, "R6");  // bypass with trap_std=1 ignored
      set_seg(5, 2, 0, 1, 0, 0,  7, "R7");  // narrow peaking, hard clipping
      set_seg(6, 1, 1, 1, 0, 1, -8, "R7");  // wide peaking, negative weight
      set_seg(7, 1, 1, 0, 0, 1,  0, "R8");  // zero weight, wide shape selected
      set_seg(8, 3, 0, 0, 1, 0,  3, "R9");  // bright input, 20/16 gain saturates
      set_seg(9, 1, 1, 0, 0, 1, -3, "R9");  // all stages, 17/16 gain
      for (int i = 0; i < NS + PAD; i++) begin
         seg_of[i] = (i < NS) ? i / SEG_LEN : NSEG - 1;
         x_arr[i]  = (i < NS) ? gen_sample(c_ptn[i / SEG_LEN], i) : 0;
      end

      repeat (3) @(negedge clk);
      check("R1", "output during reset", int'(pix_out), 0);
      rst_n = 1'b1;

      for (int k = 0; k < NS + OBS_LAG; k++) begin
         @(negedge clk);
         if (k == 0) check("R1", "output after release", int'(pix_out), 0);
         if (k >= OBS_LAG) begin
            int n;
            n = k - OBS_LAG;
            if (n >= 6 && seg_of[n-6] == seg_of[n+11]) begin
               check(c_tag[seg_of[n]], $sformatf("sample %0d", n), int'(pix_out), ref_out(n));
            end
         end
         begin
            int s;
            s = seg_of[k];
            pix_in     = 8'(xs(k));
            emph_on    = (c_emph[s] != 0);
            trap_off   = (c_toff[s] != 0);
            trap_std   = (c_std[s] != 0);
            peak_wide  = (c_wide[s] != 0);
            sharp_gain = 4'(c_sharp[s]);
         end
      end
      done = 1'b1;
      report();
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: got no end of run, expected end within 60000 cycles");
         report();
      end
   end

endmodule